// File: doc/BRIEF.md
# Serial Shift Front End with Chained Output

This block receives a three-wire serial stream (an active-low select, a serial clock and a data line) and samples all three with a fast system clock. Each line passes through a synchronizer, and the edges are found in the system clock domain. While the select is low, each rising edge of the serial clock shifts one data bit into a 16-bit register, most significant bit first. When the select rises, the register contents go to a downstream command decoder as a one-cycle word strobe. A flag marks frames that did not carry exactly 16 clock edges.

The top stage of the register drives a serial output, so several blocks can be chained. Another device in the chain sees each bit again 16 serial clocks after it was sent. A mode input selects when the output changes. In mode 0 it changes on the serial clock's falling edge, which gives a full 16-cycle lag. In mode 1 it changes on the rising edge, which gives a 15.5-cycle lag. The register is never cleared by the select, so chained data keeps moving from one frame to the next.

Top module: `ser_shift_front`

## Requirements
- R1: After reset, `sdo`, `word_valid`, `len_err` and `word_out` are all 0.
- R2: Serial clock edges have no effect while `cs_n` is high: the register, `sdo` and the bit count keep their values.
- R3: Bits are shifted in on serial clock rising edges, MSB first. After a 16-edge frame, `word_out[15]` holds the first bit sent and `word_out[0]` holds the last.
- R4: Each rising edge of `cs_n` produces exactly one `word_valid` pulse, one system cycle wide, within 5 system cycles. `word_out` and `len_err` change only together with that pulse.
- R5: At each select rise, `len_err` is set to 1 if the frame held a number of rising edges other than 16, and to 0 if it held exactly 16.
- R6: A frame with more than 16 edges still delivers the register. `word_out` then holds the last 16 bits received.
- R7: The register is not cleared when `cs_n` falls. A frame of k<16 edges delivers the low 16-k bits of the previous contents above the k new bits.
- R8: With `out_mode`=0, `sdo` takes the register's top bit after each serial clock falling edge. During the high phase it still shows the top bit from before that rising edge.
- R9: With `out_mode`=1, `sdo` takes the new top bit at each serial clock rising edge, so it is already valid during the high phase.
- R10: `sdo` holds its value while `cs_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low frame select (asynchronous) |
| sck | input | 1 | Serial clock (asynchronous) |
| sdi | input | 1 | Serial data in |
| out_mode | input | 1 | 0: sdo changes on falling edge; 1: on rising edge |
| sdo | output | 1 | Serial data out, the register's top stage |
| word_out | output | 16 | Word captured at the last select rise |
| word_valid | output | 1 | One-cycle strobe when word_out is updated |
| len_err | output | 1 | Last frame did not have exactly 16 rising edges |

## Verification
A corrupted shift register is visible at `sdo` within one serial clock edge, because that output mirrors the top stage in both modes. It also shows up in `word_out` at the next select rise. A wrong bit count cannot be seen until the select rises, and then it shows up as a wrong `len_err`. Missing or duplicated edge detection appears in the same frame, as a shifted word or as an extra or missing strobe. A wrong choice of output edge appears half a serial clock after the rising edge, as an `sdo` value that disagrees with the selected mode during the high phase.

// File: rtl/ser_shift_front.sv
module ser_shift_front #(
  parameter int WORD_W = 16,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              sdi,
  input  logic              out_mode,
  output logic              sdo,
  output logic [WORD_W-1:0] word_out,
  output logic              word_valid,
  output logic              len_err
);
  localparam int CNT_W = $clog2(WORD_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(WORD_W + 1);

  logic [SYNC_N-1:0] cs_sy, sck_sy, sdi_sy;
  logic cs_q, sck_q;
  logic [WORD_W-1:0] sr;
  logic [CNT_W-1:0] cnt;

  wire cs_s  = cs_sy[SYNC_N-1];
  wire sck_s = sck_sy[SYNC_N-1];
  wire sdi_s = sdi_sy[SYNC_N-1];

  wire cs_rise  = cs_s & ~cs_q;
  wire cs_fall  = ~cs_s & cs_q;
  wire sck_rise = sck_s & ~sck_q & ~cs_s;
  wire sck_fall = ~sck_s & sck_q & ~cs_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_sy  <= '1;
      sck_sy <= '0;
      sdi_sy <= '0;
      cs_q   <= 1'b1;
      sck_q  <= 1'b0;
    end else begin
      cs_sy  <= {cs_sy[SYNC_N-2:0], cs_n};
      sck_sy <= {sck_sy[SYNC_N-2:0], sck};
      sdi_sy <= {sdi_sy[SYNC_N-2:0], sdi};
      cs_q   <= cs_s;
      sck_q  <= sck_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr  <= '0;
      cnt <= '0;
    end else begin
      if (sck_rise) begin
        sr <= {sr[WORD_W-2:0], sdi_s};
        if (cnt != CNT_SAT) cnt <= cnt + 1'b1;
      end else if (cs_fall) begin
        cnt <= '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sdo <= 1'b0;
    else if (out_mode && sck_rise) sdo <= sr[WORD_W-2];
    else if (!out_mode && sck_fall) sdo <= sr[WORD_W-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_out   <= '0;
      word_valid <= 1'b0;
      len_err    <= 1'b0;
    end else begin
      word_valid <= cs_rise;
      if (cs_rise) begin
        word_out <= sr;
        len_err  <= (cnt != CNT_FULL);
      end
    end
  end

  p_valid_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid);
  p_word_with_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(word_out) |-> word_valid);
  p_err_with_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(len_err) |-> word_valid);
  p_sdo_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> $stable(sdo));
  p_sdo_on_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo) |-> $past(sck_rise || sck_fall));
  p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_SAT);
  p_no_shift_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> $stable(sr));
endmodule

// File: tb/ser_shift_front_tb.sv
module ser_shift_front_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, sdi = 1'b0, out_mode = 1'b0;
  logic sdo, word_valid, len_err;
  logic [15:0] word_out;
  logic [15:0] mdl = '0;
  int errors = 0, checks = 0, vcnt = 0;

  always #5 clk = ~clk;
  always @(posedge clk) if (word_valid) vcnt++;

  ser_shift_front u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
    .out_mode(out_mode), .sdo(sdo), .word_out(word_out),
    .word_valid(word_valid), .len_err(len_err)
  );

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic frame(input logic [31:0] bits, input int n);
    logic pre;
    int v0;
    v0 = vcnt;
    cs_n = 1'b0;
    #60;
    for (int i = n - 1; i >= 0; i--) begin
      sdi = bits[i];
      #60;
      chk(sdo == mdl[15], out_mode ? "R9 low phase" : "R8 low phase", sdo, mdl[15]);
      pre = mdl[15];
      mdl = {mdl[14:0], bits[i]};
      sck = 1'b1;
      #60;
      if (out_mode) chk(sdo == mdl[15], "R9 high phase", sdo, mdl[15]);
      else chk(sdo == pre, "R8 high phase", sdo, pre);
      sck = 1'b0;
    end
    #60;
    chk(vcnt == v0, "R4 no strobe inside frame", vcnt, v0);
    cs_n = 1'b1;
    #100;
    chk(vcnt == v0 + 1, "R4 one strobe", vcnt, v0 + 1);
    chk(word_out == mdl, "R3 word", word_out, mdl);
    chk(len_err == (n != 16), "R5 length flag", len_err, n != 16);
  endtask

  task automatic t_reset;
    chk(sdo == 0 && word_valid == 0 && len_err == 0 && word_out == 0, "R1 reset",
        {sdo, word_valid, len_err, word_out}, 0);
  endtask

  task automatic t_mode0_full;
    out_mode = 1'b0;
    frame(32'hA5C3, 16);
    chk(word_out == 16'hA5C3, "R3 msb first", word_out, 16'hA5C3);
    frame(32'h1E0F, 16);
  endtask

  task automatic t_idle_ignored;
    logic s0;
    logic [15:0] m0;
    s0 = sdo;
    m0 = mdl;
    sdi = 1'b1;
    for (int i = 0; i < 5; i++) begin
      sck = 1'b1; #60; sck = 1'b0; #60;
    end
    chk(sdo == s0, "R10 sdo held while idle", sdo, s0);
    frame(32'h0, 0);
    chk(word_out == m0, "R2 idle edges ignored", word_out, m0);
  endtask

  task automatic t_mode1;
    out_mode = 1'b1;
    frame(32'h5A3C, 16);
    frame(32'hFFFF, 16);
    frame(32'h0001, 16);
  endtask

  task automatic t_long;
    out_mode = 1'b0;
    frame(32'hF_1234, 20);
    chk(word_out == 16'h1234, "R6 last 16 bits", word_out, 16'h1234);
  endtask

  task automatic t_short_chain;
    frame(32'h00C7, 8);
    chk(word_out == 16'h34C7, "R7 chained contents", word_out, 16'h34C7);
    out_mode = 1'b1;
    frame(32'h5, 3);
    chk(word_out == 16'hA63D, "R7 chained in mode 1", word_out, 16'hA63D);
  endtask

  task automatic t_err_clear;
    out_mode = 1'b0;
    frame(32'h8001, 16);
    chk(len_err == 1'b0, "R5 flag cleared", len_err, 0);
  endtask

  initial begin
    #30;
    t_reset();
    rst_n = 1'b1;
    #40;
    t_reset();
    t_mode0_full();
    t_idle_ignored();
    t_mode1();
    t_long();
    t_short_chain();
    t_err_clear();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1500000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule